// File: doc/BRIEF.md
# Triggered Byte FIFO Pair

This block keeps the two byte queues that sit between the register bus and the serial shifter of an SPI host controller. Software writes outgoing bytes into the transmit queue and reads incoming bytes from the receive queue through a small register window. The shifter pops transmit bytes and pushes received bytes through plain strobes.

Each queue has a programmable threshold. When the receive queue holds at least its threshold, a receive-ready condition is raised. When the transmit queue has drained down to its threshold, a transmit-request condition is raised. These conditions feed a sticky status register with write-one-to-clear semantics, an interrupt line gated by an enable mask, and, when enabled per direction, a DMA request level. Two further status events are recorded: a byte that arrives at a full receive queue, and a transfer-complete pulse from the shifter. Either queue can be emptied in a single cycle through a self-clearing bit in the control word.

Top module: `spi_fifo_pair`

## Requirements
- R1: Queue depth is the parameter DEPTH (64 or 128). The level word (address 1) reports the receive count in bits 7:0 and the transmit count in bits 23:16, other bits zero.
- R2: A write to address 4 pushes wdata[7:0] into the transmit queue. `tx_byte` shows the oldest byte, and `tx_pop` removes it, so bytes leave in the order they were written.
- R3: `rx_push` stores `rx_byte` in the receive queue. A read strobe at address 5 returns the oldest byte in rdata[7:0] and removes it, in arrival order.
- R4: A push into a full queue is dropped and leaves the count unchanged. A receive push while the receive queue is full sets status bit 8 (overflow) on that clock edge.
- R5: The control word (address 0) holds the receive threshold in bits 7:0, receive DMA enable in bit 8, the transmit threshold in bits 23:16 and transmit DMA enable in bit 24, and reads back those fields.
- R6: Writing bit 15 or bit 31 of the control word empties the receive or the transmit queue respectively by the next cycle. Both bits always read back as zero.
- R7: Status bit 0 becomes pending one cycle after the receive count is at or above the receive threshold. Status bit 4 becomes pending one cycle after the transmit count is at or below the transmit threshold.
- R8: Writing ones to the status word (address 3) clears those bits. A threshold condition that still holds sets its bit again one cycle after the clear.
- R9: Overflow (bit 8) and transfer complete (bit 12, set by `xfer_done`) stay set when their event and a clear of that bit fall in the same cycle. Once cleared without a new event, they stay clear.
- R10: The enable word (address 2) stores only bits 0, 4, 8 and 12. `irq` is high exactly when some pending status bit has its enable set.
- R11: `rx_dma_req` equals receive DMA enable AND the receive threshold condition. `tx_dma_req` equals transmit DMA enable AND the transmit threshold condition. Neither depends on the interrupt enables.
- R12: A pop of the empty transmit queue, or a read of the empty receive queue, changes nothing. The empty read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops at address 5) |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_pop | input | 1 | Shifter takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue is full |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| irq | output | 1 | Interrupt level |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |

## Verification
The functions that can collide are a software clear of a status bit and the hardware event that sets that same bit. The bench drives a status write-one-to-clear in the same cycle as a receive push into a full queue, and again in the same cycle as a `xfer_done` pulse, and then reads the status word. The event must win for overflow and transfer complete. For the threshold bits the clear must win for exactly one cycle before the still-true condition sets the bit again, and this is judged by reading the status word in the cycle right after the clear and once more a cycle later.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_LEVEL = 3'd1,
        ADDR_IEN   = 3'd2,
        ADDR_ISTAT = 3'd3,
        ADDR_TXD   = 3'd4,
        ADDR_RXD   = 3'd5
    } reg_addr_e;

    // status / enable bit positions
    localparam int BIT_RXRDY = 0;
    localparam int BIT_TXREQ = 4;
    localparam int BIT_RXOVF = 8;
    localparam int BIT_DONE  = 12;

    // control word bit positions
    localparam int BIT_RXDMA   = 8;
    localparam int BIT_RXFLUSH = 15;
    localparam int BIT_TXDMA   = 24;
    localparam int BIT_TXFLUSH = 31;

    // index of each flag inside the 4-bit internal vector
    localparam int IDX_RXRDY = 0;
    localparam int IDX_TXREQ = 1;
    localparam int IDX_RXOVF = 2;
    localparam int IDX_DONE  = 3;
    localparam int NFLAGS    = 4;

    // flags that follow a level condition (clear wins for one cycle)
    localparam logic [NFLAGS-1:0] LEVEL_FLAGS = 4'b0011;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [7:0]                   din,
    input  logic                         pop,
    output logic [7:0]                   dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign dout  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count));

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/fifo_event_ctrl.sv
module fifo_event_ctrl
    import fifo_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_in,
    input  logic [NFLAGS-1:0] clr_in,
    input  logic              en_we,
    input  logic [NFLAGS-1:0] en_wdata,
    output logic [NFLAGS-1:0] pend,
    output logic [NFLAGS-1:0] en,
    output logic              irq
);
    typedef struct packed {
        logic [NFLAGS-1:0] pend;
        logic [NFLAGS-1:0] en;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAGS; i++) begin
            if (LEVEL_FLAGS[i]) begin
                st_d.pend[i] = clr_in[i] ? 1'b0 : (st_q.pend[i] | set_in[i]);
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~clr_in[i]) | set_in[i];
            end
        end
        if (en_we) st_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;
    assign irq  = |(st_q.pend & st_q.en);

    assert_rxrdy_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_in[IDX_RXRDY] && !clr_in[IDX_RXRDY]) |=> pend[IDX_RXRDY]);

    assert_level_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_in[IDX_TXREQ] |=> !pend[IDX_TXREQ]);

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_in[IDX_RXOVF] |=> pend[IDX_RXOVF]);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_empty,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic        rx_full,
    input  logic        xfer_done,
    output logic        irq,
    output logic        tx_dma_req,
    output logic        rx_dma_req
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [7:0] rx_thr;
        logic       rx_dma;
        logic [7:0] tx_thr;
        logic       tx_dma;
    } ctrl_st_t;

    ctrl_st_t ctrl_d, ctrl_q;

    logic            wr_ctrl, wr_ien, wr_istat, wr_txd, rd_rxd;
    logic            rx_flush, tx_flush;
    logic [CW-1:0]   rx_cnt, tx_cnt;
    logic [7:0]      rx_cnt8, tx_cnt8, rx_head;
    logic            tx_full, rx_empty;
    logic            rx_hit, tx_hit;
    logic [NFLAGS-1:0] set_v, clr_v, en_wv, pend_v, en_v;
    logic [31:0]     stat_word, ien_word;
    logic            unused_wdata;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_ien   = reg_wr && (reg_addr == ADDR_IEN);
    assign wr_istat = reg_wr && (reg_addr == ADDR_ISTAT);
    assign wr_txd   = reg_wr && (reg_addr == ADDR_TXD);
    assign rd_rxd   = reg_rd && (reg_addr == ADDR_RXD);
    assign rx_flush = wr_ctrl && reg_wdata[BIT_RXFLUSH];
    assign tx_flush = wr_ctrl && reg_wdata[BIT_TXFLUSH];
    assign unused_wdata = ^reg_wdata;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.rx_thr = reg_wdata[7:0];
            ctrl_d.rx_dma = reg_wdata[BIT_RXDMA];
            ctrl_d.tx_thr = reg_wdata[23:16];
            ctrl_d.tx_dma = reg_wdata[BIT_TXDMA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (wr_txd),
        .din   (reg_wdata[7:0]),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rd_rxd),
        .dout  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_cnt8 = 8'(rx_cnt);
    assign tx_cnt8 = 8'(tx_cnt);
    assign rx_hit  = (rx_cnt8 >= ctrl_q.rx_thr);
    assign tx_hit  = (tx_cnt8 <= ctrl_q.tx_thr);

    always_comb begin
        set_v            = '0;
        set_v[IDX_RXRDY] = rx_hit;
        set_v[IDX_TXREQ] = tx_hit;
        set_v[IDX_RXOVF] = rx_push && rx_full;
        set_v[IDX_DONE]  = xfer_done;
        clr_v            = '0;
        clr_v[IDX_RXRDY] = wr_istat && reg_wdata[BIT_RXRDY];
        clr_v[IDX_TXREQ] = wr_istat && reg_wdata[BIT_TXREQ];
        clr_v[IDX_RXOVF] = wr_istat && reg_wdata[BIT_RXOVF];
        clr_v[IDX_DONE]  = wr_istat && reg_wdata[BIT_DONE];
        en_wv            = '0;
        en_wv[IDX_RXRDY] = reg_wdata[BIT_RXRDY];
        en_wv[IDX_TXREQ] = reg_wdata[BIT_TXREQ];
        en_wv[IDX_RXOVF] = reg_wdata[BIT_RXOVF];
        en_wv[IDX_DONE]  = reg_wdata[BIT_DONE];
    end

    fifo_event_ctrl u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_in   (set_v),
        .clr_in   (clr_v),
        .en_we    (wr_ien),
        .en_wdata (en_wv),
        .pend     (pend_v),
        .en       (en_v),
        .irq      (irq)
    );

    always_comb begin
        stat_word            = '0;
        stat_word[BIT_RXRDY] = pend_v[IDX_RXRDY];
        stat_word[BIT_TXREQ] = pend_v[IDX_TXREQ];
        stat_word[BIT_RXOVF] = pend_v[IDX_RXOVF];
        stat_word[BIT_DONE]  = pend_v[IDX_DONE];
        ien_word             = '0;
        ien_word[BIT_RXRDY]  = en_v[IDX_RXRDY];
        ien_word[BIT_TXREQ]  = en_v[IDX_TXREQ];
        ien_word[BIT_RXOVF]  = en_v[IDX_RXOVF];
        ien_word[BIT_DONE]   = en_v[IDX_DONE];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[7:0]       = ctrl_q.rx_thr;
                reg_rdata[BIT_RXDMA] = ctrl_q.rx_dma;
                reg_rdata[23:16]     = ctrl_q.tx_thr;
                reg_rdata[BIT_TXDMA] = ctrl_q.tx_dma;
            end
            ADDR_LEVEL: begin
                reg_rdata[7:0]   = rx_cnt8;
                reg_rdata[23:16] = tx_cnt8;
            end
            ADDR_IEN:   reg_rdata = ien_word;
            ADDR_ISTAT: reg_rdata = stat_word;
            ADDR_RXD:   reg_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            default:    reg_rdata = '0;
        endcase
    end

    assign rx_dma_req = ctrl_q.rx_dma && rx_hit;
    assign tx_dma_req = ctrl_q.tx_dma && tx_hit;

    assert_tx_push_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full && !tx_pop && !tx_flush) |=> tx_full);

    assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.rx_dma) |-> !rx_dma_req);

endmodule

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic        reg_rd;
    logic [31:0] reg_rdata;
    logic        tx_pop;
    logic [7:0]  tx_byte;
    logic        tx_empty;
    logic        rx_push;
    logic [7:0]  rx_byte;
    logic        rx_full;
    logic        xfer_done;
    logic        irq;
    logic        tx_dma_req;
    logic        rx_dma_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_fifo_pair #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
        .xfer_done(xfer_done), .irq(irq), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rx_read(output logic [31:0] d);
        reg_addr = 3'd5; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_byte = b; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_out(input logic [7:0] exp_b, input string tag);
        check(tag, {24'h0, tx_byte}, {24'h0, exp_b});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R12 reset tx_empty", {31'h0, tx_empty}, 32'h1);
        check("R10 reset irq", {31'h0, irq}, 32'h0);
        peek(3'd1, v); check("R1 reset level", v, 32'h0);
        peek(3'd3, v); check("R8 reset status", v, 32'h0);
    endtask

    task automatic t_tx_order();
        logic [31:0] v;
        wr(3'd0, 32'h8002_8000);          // flush both, tx threshold 2
        wr(3'd4, 32'hA1); wr(3'd4, 32'hB2); wr(3'd4, 32'hC3);
        peek(3'd1, v); check("R1 tx count field", v, 32'h0003_0000);
        wr(3'd3, 32'h0000_1111);
        idle(1);
        peek(3'd3, v); check("R7 tx request idle above threshold", v & 32'h10, 32'h0);
        tx_out(8'hA1, "R2 tx head first");
        idle(1);
        peek(3'd3, v); check("R7 tx request at threshold", v & 32'h10, 32'h10);
        tx_out(8'hB2, "R2 tx head second");
        tx_out(8'hC3, "R2 tx head third");
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        peek(3'd1, v); check("R12 pop of empty tx", v, 32'h0);
    endtask

    task automatic t_rx_order();
        logic [31:0] v;
        wr(3'd0, 32'h8000_8000);
        rx_in(8'h11); rx_in(8'h22); rx_in(8'h33);
        peek(3'd1, v); check("R1 rx count field", v, 32'h0000_0003);
        rx_read(v); check("R3 rx first", v, 32'h11);
        rx_read(v); check("R3 rx second", v, 32'h22);
        rx_read(v); check("R3 rx third", v, 32'h33);
        rx_read(v); check("R12 empty rx read value", v, 32'h0);
        peek(3'd1, v); check("R12 empty rx read count", v, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(3'd0, 32'h8000_8000);
        for (int i = 0; i < DEPTH; i++) rx_in(8'(i));
        peek(3'd1, v); check("R1 rx full count", v, 32'(DEPTH));
        wr(3'd3, 32'h0000_1111);
        peek(3'd3, v); check("R4 no overflow yet", v & 32'h100, 32'h0);
        rx_in(8'hEE);
        peek(3'd3, v); check("R4 overflow flag", v & 32'h100, 32'h100);
        peek(3'd1, v); check("R4 dropped push count", v, 32'(DEPTH));
        rx_read(v); check("R4 oldest byte kept", v, 32'h00);
        rx_in(8'h55);
        // clear overflow while a new overflow arrives
        reg_addr = 3'd3; reg_wdata = 32'h100; reg_wr = 1'b1;
        rx_byte = 8'h66; rx_push = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rx_push = 1'b0;
        peek(3'd3, v); check("R9 overflow beats clear", v & 32'h100, 32'h100);
        wr(3'd3, 32'h100);
        peek(3'd3, v); check("R9 overflow cleared", v & 32'h100, 32'h0);
        idle(1);
        peek(3'd3, v); check("R9 overflow stays clear", v & 32'h100, 32'h0);
        reg_addr = 3'd3; reg_wdata = 32'h1000; reg_wr = 1'b1; xfer_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; xfer_done = 1'b0;
        peek(3'd3, v); check("R9 done beats clear", v & 32'h1000, 32'h1000);
        wr(3'd3, 32'h1000);
        idle(1);
        peek(3'd3, v); check("R9 done cleared", v & 32'h1000, 32'h0);
    endtask

    task automatic t_ctrl_flush_dma();
        logic [31:0] v;
        rx_in(8'h01); rx_in(8'h02);
        wr(3'd4, 32'h7); wr(3'd4, 32'h8);
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h8105_8107);
        peek(3'd1, v); check("R6 both flushed", v, 32'h0);
        peek(3'd0, v); check("R5 R6 control readback", v, 32'h0105_0107);
        check("R11 rx dma below threshold", {31'h0, rx_dma_req}, 32'h0);
        check("R11 tx dma at low level", {31'h0, tx_dma_req}, 32'h1);
        for (int i = 0; i < 6; i++) wr(3'd4, 32'(i));
        check("R11 tx dma above threshold", {31'h0, tx_dma_req}, 32'h0);
        for (int i = 0; i < 7; i++) rx_in(8'(i));
        check("R11 rx dma at threshold", {31'h0, rx_dma_req}, 32'h1);
        check("R11 dma with irq masked", {31'h0, irq}, 32'h0);
        rx_read(v);
        check("R11 rx dma drops below", {31'h0, rx_dma_req}, 32'h0);
    endtask

    task automatic t_reassert();
        logic [31:0] v;
        wr(3'd0, 32'h8000_8002);
        rx_in(8'hAA); rx_in(8'hBB);
        idle(1);
        peek(3'd3, v); check("R7 rx ready pending", v & 32'h1, 32'h1);
        wr(3'd3, 32'h1);
        peek(3'd3, v); check("R8 clear wins one cycle", v & 32'h1, 32'h0);
        idle(1);
        peek(3'd3, v); check("R8 condition sets again", v & 32'h1, 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(3'd2, 32'hFFFF_FFFF);
        peek(3'd2, v); check("R10 enable readback", v, 32'h0000_1111);
        check("R10 irq with pending", {31'h0, irq}, 32'h1);
        wr(3'd2, 32'h1000);
        wr(3'd3, 32'h1111);
        check("R10 irq masked", {31'h0, irq}, 32'h0);
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        check("R10 irq on done", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
        tx_pop = 1'b0; rx_push = 1'b0; rx_byte = '0; xfer_done = 1'b0;
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_tx_order();
        t_rx_order();
        t_overflow();
        t_ctrl_flush_dma();
        t_reassert();
        t_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule